// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block runs one-word transactions against a three-wire serial EEPROM with a chip select, a serial clock, a data line toward the device and a data line back from it. A host requests a transaction by pulsing `start` while the block is idle. With the pulse it presents an operation code, a word address, a 16-bit write word and a device-size select. The block frames the request serially, paces every serial bit with a programmable half-period divider, and for a read collects the returned word. It then raises `done` for one cycle.

Four operations are supported. A read returns a word. A write stores a word. Write-enable and write-disable each send only a command and a fixed address pattern. The block also drives a software-access flag and an output-enable for the external pad. Around the serial bits it opens and closes the bus in two separate steps each, so the device always sees chip select change while the other controls are steady.

Top module: `mw_eeprom_master`

## Requirements
- R1: The `op` input is decoded as 0 = read, 1 = write, 2 = write-enable, 3 = write-disable. Every frame opens with a 3-bit command sent most significant bit first: 110 for read, 101 for write, 100 for both write-enable and write-disable.
- R2: Right after the command comes the address field, sent most significant bit first. It is the low 6 bits of the address when `smallDev` is 1 and all 8 bits when `smallDev` is 0.
- R3: Write-enable replaces the address with the low field bits of 0x30, so 110000 for 6 bits and 00110000 for 8 bits. Write-disable replaces it with all zeros. Both frames end after the address field, giving 9 or 11 clock pulses in total.
- R4: A write sends the 16-bit `wrData` word after the address, most significant bit first, giving 25 or 27 clock pulses in total.
- R5: A read captures `eeDi` once per data bit, one system cycle after the serial clock is seen high, filling `rdData` from bit 15 down to bit 0. `rdData` holds the full word in the cycle `done` is high.
- R6: Each serial bit puts the bit on `eeDo` with `eeSck` low for H system cycles, then raises `eeSck` for H cycles with `eeDo` unchanged. H is `halfDiv` latched while idle, and a value of 0 counts as 1.
- R7: From the low half of the first read data bit until the transaction ends, `eeOe` is 0 and `eeDo` is 0. Before that point, and throughout the other operations, `eeOe` is 1 while the bus is open.
- R8: Opening takes two steps. `eeSwEn` and `eeOe` rise together with `eeCs` and `eeSck` low. `eeCs` rises H cycles later, before the first clock pulse.
- R9: Closing takes two steps. `eeCs` falls while `eeSck` and `eeSwEn` are still high. H cycles later `eeSck`, `eeDo`, `eeOe` and `eeSwEn` all go low together.
- R10: `start` is accepted only when `busy` is 0. It is ignored while a transaction runs. `busy` is 1 from the cycle after an accepted start until the closing step completes.
- R11: `done` is a one-cycle pulse. It rises in the same cycle that `busy` falls.
- R12: While `rstN` is low at a clock edge, the block returns to idle with `busy`, `done`, `eeCs`, `eeSck`, `eeDo`, `eeOe`, `eeSwEn` low and `rdData` cleared, even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a transaction (taken only when idle) |
| op | input | 2 | Operation: 0 read, 1 write, 2 write-enable, 3 write-disable |
| addr | input | 8 | Word address |
| wrData | input | 16 | Word to write |
| smallDev | input | 1 | 1 selects the 6-bit address field, 0 the 8-bit field |
| halfDiv | input | 16 | Serial half period in system cycles (0 counts as 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last word read |
| eeCs | output | 1 | Device chip select |
| eeSck | output | 1 | Serial clock |
| eeDo | output | 1 | Serial data toward the device |
| eeOe | output | 1 | Output enable for the data pad |
| eeSwEn | output | 1 | Software-access flag, high while the bus is open |
| eeDi | input | 1 | Serial data from the device |

## Verification
Two kinds of wrong internal state show at the ports on the first affected clock pulse.

- A wrong bit counter or wrong frame register gives a clock-pulse count or a captured bit stream that differs from the expected frame for that operation.
- A wrong divider count gives a low or high half that differs from H.

Faults in the opening and closing steps show within one half period of the bus edge concerned:

- a stuck output-enable shows as a driven data line during read data;
- a wrong close order shows as chip select falling with the clock already low.

A receive shift that is misaligned by one bit appears only at `done`, as a shifted `rdData`. A start that is wrongly accepted while busy appears as a second, unexpected `done`.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDIS = 2'd3
  } mwOp_e;

  // Strobes and levels passed from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture a new frame
    logic shift;   // advance to the next outgoing bit
    logic csLvl;   // chip select level
    logic sckLvl;  // serial clock level
    logic swLvl;   // software access level
    logic oeLvl;   // pad output enable level
    logic txLvl;   // data line carries a frame bit
    logic rxLvl;   // read data phase
  } mwStrobe_t;

  function automatic logic [OPC_W-1:0] opcodeOf(input mwOp_e op);
    case (op)
      OP_READ:  opcodeOf = 3'b110;
      OP_WRITE: opcodeOf = 3'b101;
      default:  opcodeOf = 3'b100;
    endcase
  endfunction

  function automatic logic hasData(input mwOp_e op);
    hasData = (op == OP_READ) || (op == OP_WRITE);
  endfunction

endpackage

// File: rtl/mw_clk_div.sv
module mw_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             tick
);

  logic [DIV_W-1:0] hpQ;
  logic [DIV_W-1:0] cnt;

  assign tick = !clr && (cnt == hpQ - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hpQ <= DIV_W'(1);
      cnt <= '0;
    end else if (clr) begin
      hpQ <= (halfDiv == '0) ? DIV_W'(1) : halfDiv;
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R6: the half-period count never passes the latched limit
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < hpQ);

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int ADDR_W_SMALL = 6,
  parameter int DATA_W       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  mwOp_e      op,
  input  logic       smallDev,
  input  logic       tick,
  output logic       busy,
  output logic       done,
  output logic       divClr,
  output mwStrobe_t  strb
);

  localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIG   = CNT_W'(OPC_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_SMALL = CNT_W'(OPC_W + ADDR_W_SMALL - 1);
  localparam logic [CNT_W-1:0] DATA_BITS  = CNT_W'(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SELECT, ST_LOW, ST_HIGH, ST_CLOSE, ST_DROP
  } ctrlSt_e;

  ctrlSt_e          state;
  mwOp_e            opQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] startCnt;
  logic             doneQ;
  logic             inData;

  assign startCnt = (smallDev ? LAST_SMALL : LAST_BIG)
                  + (hasData(op) ? DATA_BITS : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opQ    <= OP_READ;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (state == ST_DROP);
      case (state)
        ST_IDLE: if (start) begin
          opQ    <= op;
          bitCnt <= startCnt;
          state  <= ST_SETUP;
        end
        ST_SETUP:  if (tick) state <= ST_SELECT;
        ST_SELECT: if (tick) state <= ST_LOW;
        ST_LOW:    if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (bitCnt == '0) begin
            state <= ST_CLOSE;
          end else begin
            bitCnt <= bitCnt - CNT_W'(1);
            state  <= ST_LOW;
          end
        end
        ST_CLOSE:  if (tick) state <= ST_DROP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign inData = (opQ == OP_READ) && (bitCnt < DATA_BITS);

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && start;
    strb.shift  = (state == ST_HIGH) && tick && (bitCnt != '0);
    strb.csLvl  = (state == ST_SELECT) || (state == ST_LOW) || (state == ST_HIGH);
    strb.sckLvl = (state == ST_HIGH) || (state == ST_CLOSE);
    strb.swLvl  = (state != ST_IDLE) && (state != ST_DROP);
    strb.oeLvl  = strb.swLvl && !inData;
    strb.txLvl  = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_CLOSE);
    strb.rxLvl  = inData && ((state == ST_LOW) || (state == ST_HIGH));
  end

  assign busy   = (state != ST_IDLE);
  assign done   = doneQ;
  assign divClr = (state == ST_IDLE);

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: an accepted start makes the block busy on the next cycle
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R11: the busy flag falls exactly when completion is signalled
  a_r11_done_with_idle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int ADDR_W_SMALL = 6,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobe_t         strb,
  input  mwOp_e             op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              smallDev,
  input  logic              eeDi,
  output logic              eeCs,
  output logic              eeSck,
  output logic              eeDo,
  output logic              eeOe,
  output logic              eeSwEn,
  output logic [DATA_W-1:0] rdData
);

  localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
  localparam int PAD_W   = ADDR_W - ADDR_W_SMALL;

  logic [ADDR_W-1:0]  addrEff;
  logic [FRAME_W-1:0] frameBig;
  logic [FRAME_W-1:0] frameSmall;
  logic [FRAME_W-1:0] txQ;
  logic [DATA_W-1:0]  rdQ;
  logic               rxQ;
  logic               sckPrev;

  always_comb begin
    case (op)
      OP_WREN:  addrEff = ADDR_W'(8'h30);
      OP_WRDIS: addrEff = '0;
      default:  addrEff = addr;
    endcase
  end

  assign frameBig   = {opcodeOf(op), addrEff, wrData};
  assign frameSmall = FRAME_W'({opcodeOf(op), addrEff[ADDR_W_SMALL-1:0], wrData}) << PAD_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ     <= '0;
      rdQ     <= '0;
      rxQ     <= 1'b0;
      sckPrev <= 1'b0;
      eeCs    <= 1'b0;
      eeSck   <= 1'b0;
      eeDo    <= 1'b0;
      eeOe    <= 1'b0;
      eeSwEn  <= 1'b0;
    end else begin
      if (strb.load)       txQ <= smallDev ? frameSmall : frameBig;
      else if (strb.shift) txQ <= txQ << 1;
      if (rxQ && eeSck && !sckPrev) rdQ <= {rdQ[DATA_W-2:0], eeDi};
      rxQ     <= strb.rxLvl;
      sckPrev <= eeSck;
      eeCs    <= strb.csLvl;
      eeSck   <= strb.sckLvl;
      eeOe    <= strb.oeLvl;
      eeSwEn  <= strb.swLvl;
      eeDo    <= strb.txLvl && strb.oeLvl && txQ[FRAME_W-1];
    end
  end

  assign rdData = rdQ;

  // R8: chip select is only ever high inside an open bus
  a_r8_cs_inside_access: assert property (@(posedge clk) disable iff (!rstN)
    eeCs |-> eeSwEn);

  // R9: chip select drops while the clock and access flag are still high
  a_r9_cs_drop_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeCs) |-> (eeSck && eeSwEn));

  // R6: the data line does not move while the clock stays high
  a_r6_data_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (eeSck && $past(eeSck)) |-> $stable(eeDo));

  // R7: every read sample is taken with the pad driver released
  a_r7_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    (rxQ && eeSck && !sckPrev) |-> !eeOe);

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int ADDR_W_SMALL = 6,
  parameter int DATA_W       = 16,
  parameter int DIV_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              smallDev,
  input  logic [DIV_W-1:0]  halfDiv,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              eeCs,
  output logic              eeSck,
  output logic              eeDo,
  output logic              eeOe,
  output logic              eeSwEn,
  input  logic              eeDi
);

  mwStrobe_t strb;
  logic      tick;
  logic      divClr;
  mwOp_e     opSel;

  assign opSel = mwOp_e'(op);

  mw_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (divClr),
    .halfDiv (halfDiv),
    .tick    (tick)
  );

  mw_ctrl #(
    .ADDR_W       (ADDR_W),
    .ADDR_W_SMALL (ADDR_W_SMALL),
    .DATA_W       (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .op       (opSel),
    .smallDev (smallDev),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .divClr   (divClr),
    .strb     (strb)
  );

  mw_datapath #(
    .ADDR_W       (ADDR_W),
    .ADDR_W_SMALL (ADDR_W_SMALL),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .op       (opSel),
    .addr     (addr),
    .wrData   (wrData),
    .smallDev (smallDev),
    .eeDi     (eeDi),
    .eeCs     (eeCs),
    .eeSck    (eeSck),
    .eeDo     (eeDo),
    .eeOe     (eeOe),
    .eeSwEn   (eeSwEn),
    .rdData   (rdData)
  );

endmodule

// File: tb/mw_eeprom_master_bench.sv
module mw_eeprom_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  addr = 8'd0;
  logic [15:0] wrData = 16'd0;
  logic        smallDev = 1'b0;
  logic [15:0] halfDiv = 16'd1;
  logic        eeDi = 1'b0;
  logic        busy, done, eeCs, eeSck, eeDo, eeOe, eeSwEn;
  logic [15:0] rdData;

  always #2.5 clk = ~clk;

  mw_eeprom_master u_mw_eeprom_master (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .addr(addr),
    .wrData(wrData), .smallDev(smallDev), .halfDiv(halfDiv),
    .busy(busy), .done(done), .rdData(rdData), .eeCs(eeCs),
    .eeSck(eeSck), .eeDo(eeDo), .eeOe(eeOe), .eeSwEn(eeSwEn), .eeDi(eeDi)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int          nBits;
    logic [31:0] frame;
    bit          isRead;
    logic [15:0] rdExp;
    int          hp;
    int          aw;
    string       tag;
  } item_t;

  item_t expQ[$];

  // monitor state
  item_t cur;
  bit    haveCur = 0;
  logic  sckPrev = 0, csPrev = 0, swPrev = 0;
  int    cyc = 0, riseCnt = 0, lowLen = 0, highLen = 0;
  int    periodErr = 0, holdErr = 0, oeErr = 0;
  int    swRiseAt = 0, csFallAt = 0, swFallAt = 0;
  bit    setupOk = 0, closeOrderOk = 0, checkDoneLow = 0;
  logic  doAtRise = 0;
  logic [31:0] frameGot = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      haveCur = 0; sckPrev = 0; csPrev = 0; swPrev = 0; checkDoneLow = 0;
    end else begin
      cyc++;
      if (checkDoneLow) begin
        check(!done, "R11", "done longer than one cycle", done, 0);
        checkDoneLow = 0;
      end
      if (eeSwEn && !swPrev) begin
        haveCur = (expQ.size() > 0);
        if (haveCur) cur = expQ[0];
        swRiseAt = cyc; riseCnt = 0; frameGot = 0;
        periodErr = 0; holdErr = 0; oeErr = 0; setupOk = 0; closeOrderOk = 0;
        if (eeCs || eeSck || !eeOe) setupOk = 0;
      end
      if (eeCs && !csPrev && haveCur)
        setupOk = ((cyc - swRiseAt) == cur.hp) && eeSwEn && eeOe && !eeSck;
      if (!eeCs && csPrev) begin
        csFallAt = cyc;
        closeOrderOk = eeSck && eeSwEn;
      end
      if (!eeSwEn && swPrev) swFallAt = cyc;
      if (haveCur) begin
        if (eeSck && !sckPrev) begin
          if (riseCnt > 0 && lowLen != cur.hp) periodErr++;
          frameGot = {frameGot[30:0], eeDo};
          doAtRise = eeDo;
          if (cur.isRead && riseCnt >= 3 + cur.aw) begin
            if (eeOe || eeDo) oeErr++;
          end else if (!eeOe) oeErr++;
          riseCnt++;
          highLen = 1;
        end else if (eeSck) begin
          highLen++;
          if (eeDo !== doAtRise) holdErr++;
        end else if (!eeSck && sckPrev) begin
          if (riseCnt < cur.nBits && highLen != cur.hp) periodErr++;
          lowLen = 1;
          if (cur.isRead && riseCnt >= 3 + cur.aw && riseCnt < 3 + cur.aw + 16)
            eeDi = cur.rdExp[15 - (riseCnt - 3 - cur.aw)];
        end else begin
          lowLen++;
        end
      end
      if (done) begin
        if (!haveCur || expQ.size() == 0) begin
          check(0, "R10", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(riseCnt == it.nBits, it.tag, "clock pulse count", riseCnt, it.nBits);
          check(frameGot == it.frame, it.tag, "serial frame", frameGot, it.frame);
          if (it.isRead) begin
            check(rdData == it.rdExp, "R5", "read word", rdData, it.rdExp);
            check(oeErr == 0, "R7", "driver release in read data", oeErr, 0);
          end else begin
            check(oeErr == 0, "R7", "driver enabled outside read data", oeErr, 0);
          end
          check(periodErr == 0, "R6", "half period length", periodErr, 0);
          check(holdErr == 0, "R6", "data moved while clock high", holdErr, 0);
          check(setupOk, "R8", "open sequence", setupOk, 1);
          check(closeOrderOk && ((swFallAt - csFallAt) == it.hp), "R9",
                "close sequence gap", swFallAt - csFallAt, it.hp);
          check(!eeCs && !eeSck && !eeDo && !eeOe && !eeSwEn && !busy, "R9",
                "bus idle at done", {eeCs, eeSck, eeDo, eeOe, eeSwEn, busy}, 0);
          checkDoneLow = 1;
        end
        haveCur = 0;
      end
      sckPrev = eeSck; csPrev = eeCs; swPrev = eeSwEn;
    end
  end

  task automatic runOp(input logic [1:0] o, input logic [7:0] a, input logic [15:0] wd,
                       input logic [15:0] pat, input bit sm, input int hd,
                       input string tag, input bit poke);
    item_t it;
    logic [2:0]  oc;
    logic [7:0]  af;
    logic [31:0] f;
    it.aw = sm ? 6 : 8;
    oc = (o == 2'd0) ? 3'b110 : (o == 2'd1) ? 3'b101 : 3'b100;
    af = (o == 2'd2) ? 8'h30 : (o == 2'd3) ? 8'h00 : a;
    f = 0;
    for (int i = 2; i >= 0; i--) f = {f[30:0], oc[i]};
    for (int i = it.aw - 1; i >= 0; i--) f = {f[30:0], af[i]};
    if (o == 2'd1) for (int i = 15; i >= 0; i--) f = {f[30:0], wd[i]};
    if (o == 2'd0) for (int i = 15; i >= 0; i--) f = {f[30:0], 1'b0};
    it.frame  = f;
    it.nBits  = 3 + it.aw + ((o < 2'd2) ? 16 : 0);
    it.isRead = (o == 2'd0);
    it.rdExp  = pat;
    it.hp     = (hd == 0) ? 1 : hd;
    it.tag    = tag;
    expQ.push_back(it);
    @(negedge clk);
    check(!busy, "R10", "idle before start", busy, 0);
    op = o; addr = a; wrData = wd; smallDev = sm; halfDiv = 16'(hd); start = 1;
    @(negedge clk);
    start = 0;
    check(busy, "R10", "busy after start", busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      op = 2'd1; start = 1;   // R10: must be ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !eeCs && !eeSck && !eeDo && !eeOe && !eeSwEn && rdData == 0,
          "R12", "reset state", {busy, done, eeCs, eeSck, eeDo, eeOe, eeSwEn}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    runOp(2'd0, 8'h5A, 16'h0000, 16'hA5C3, 0, 1, "R1", 0);  // read, 8-bit address
    runOp(2'd0, 8'hE7, 16'h0000, 16'h8001, 1, 3, "R2", 0);  // read, 6-bit address
    runOp(2'd1, 8'hC4, 16'hBEEF, 16'h0000, 0, 2, "R4", 0);  // write, 8-bit
    runOp(2'd1, 8'h3F, 16'h1234, 16'h0000, 1, 1, "R4", 0);  // write, 6-bit
    runOp(2'd2, 8'hFF, 16'hFFFF, 16'h0000, 0, 2, "R3", 0);  // write-enable, 8-bit
    runOp(2'd2, 8'h00, 16'h0000, 16'h0000, 1, 1, "R3", 0);  // write-enable, 6-bit
    runOp(2'd3, 8'hFF, 16'hFFFF, 16'h0000, 0, 1, "R3", 0);  // write-disable
    runOp(2'd0, 8'h01, 16'h0000, 16'h7FFE, 0, 0, "R6", 0);  // divider 0 acts as 1
    runOp(2'd0, 8'h80, 16'h0000, 16'h3C5A, 0, 2, "R10", 1); // start during busy
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending items after ignored start", expQ.size(), 0);
    // R12: reset in the middle of a transaction
    op = 2'd1; smallDev = 0; halfDiv = 16'd2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (25) @(negedge clk);
    rstN = 0;
    repeat (2) @(negedge clk);
    check(!busy && !eeCs && !eeSck && !eeDo && !eeOe && !eeSwEn && rdData == 0,
          "R12", "reset mid transaction", {busy, eeCs, eeSck, eeDo, eeOe, eeSwEn, rdData}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    runOp(2'd0, 8'h33, 16'h0000, 16'hFFFF, 1, 2, "R5", 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule